// File: doc/BRIEF.md
# Fiber Link Monitor with Far-End-Fault Signalling

This block watches the optical receiver's signal-detect indication, which arrives already quantized into three classes: below the disable threshold, low, and high. A class is adopted only after it has stayed unchanged for a programmable number of clocks. The adopted class sets three things. It decides whether the port runs as a fiber port, and a fiber port always skips auto-negotiation. It reports whether the link is up, and the link LED follows that report.

While the port is in fiber mode and the received signal has been lost, the block warns the remote station. It places a fault pattern into the idle gaps of the transmit stream. The pattern is a repeating group of 84 ones followed by a single zero. The transmit path tells the block when it wants to send a frame. The block tells the transmit path when a frame may start, and it supplies a bit stream together with a select line that the idle multiplexer uses. A fault group never starts while a frame is requested. A group that has already started always runs to its zero bit, and any new frame waits until then.

Top module: `fiber_link_mon`

## Requirements
- R1: While reset is high and in the first cycle after it, fiber_mode, link_up, link_led, autoneg_bypass and fef_sel are 0 and tx_frame_ok is 1.
- R2: sd_level is coded 2'b00 = below disable, 2'b01 = low, 2'b10 = high, and 2'b11 is treated as low. A new class held for DEBOUNCE_CYCLES+1 consecutive clock samples is adopted. A class held for DEBOUNCE_CYCLES samples or fewer leaves every output unchanged.
- R3: When the adopted class is below disable, fiber_mode, link_up and link_led are 0 and no fault group starts.
- R4: When the adopted class is low (2'b01 or 2'b11), fiber_mode is 1, link_up and link_led are 0, and fault groups are sent.
- R5: When the adopted class is high, fiber_mode, link_up and link_led are 1 and no fault group starts.
- R6: autoneg_bypass equals fiber_mode at all times.
- R7: A fault group holds fef_sel at 1 for 85 consecutive cycles. During those cycles fef_bit is 1 for the first 84 and 0 for the last. While the fault persists and no frame is requested, a new group starts in the cycle right after the zero bit.
- R8: A fault group starts only in a cycle where tx_frame_req is 0. While a frame request is held and no group is running, fef_sel stays 0.
- R9: A started group always completes all 85 bits, even if the frame request rises or the fault clears during it. tx_frame_ok is 0 for the whole group and returns to 1 in the cycle after the zero bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_level | input | 2 | Quantized signal-detect class from the optical module |
| tx_frame_req | input | 1 | Transmit path wants to send or is sending a frame |
| tx_frame_ok | output | 1 | A frame may start or continue in this cycle |
| fiber_mode | output | 1 | Port runs as a fiber port |
| link_up | output | 1 | Link is considered active |
| link_led | output | 1 | Link-active LED drive |
| autoneg_bypass | output | 1 | Auto-negotiation is skipped |
| fef_sel | output | 1 | Idle multiplexer selects the fault stream |
| fef_bit | output | 1 | Current fault-pattern bit |

## Verification
The assertions check four rules on every cycle. An adopted class must match the input of the two previous samples. A link can only be up in fiber mode. A group can only start while no frame is requested. A group, once into its ones, must run on, and a zero bit never repeats. Only the directed scenarios can show the rest: the exact count of 84 ones before each zero, the exact debounce length at both edges of the window, the LED and link values for every class including the treatment of 2'b11, and the timing of frames that are held back by a group.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic [1:0] {
        SD_OFF  = 2'b00,
        SD_LOW  = 2'b01,
        SD_HIGH = 2'b10
    } sd_class_t;

    typedef struct packed {
        logic fiber;
        logic link;
        logic led;
        logic bypass;
        logic fault;
    } link_view_t;

    function automatic sd_class_t classify(input logic [1:0] raw);
        case (raw)
            2'b00:   return SD_OFF;
            2'b10:   return SD_HIGH;
            default: return SD_LOW;
        endcase
    endfunction

    function automatic link_view_t decode_class(input sd_class_t cls);
        link_view_t v;
        v.fiber  = (cls != SD_OFF);
        v.link   = (cls == SD_HIGH);
        v.led    = (cls == SD_HIGH);
        v.bypass = (cls != SD_OFF);
        v.fault  = (cls == SD_LOW);
        return v;
    endfunction

endpackage

// File: rtl/fl_sd_filter.sv
module fl_sd_filter
    import fl_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  sd_class_t raw_cls,
    output sd_class_t acc_cls
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(DEBOUNCE_CYCLES - 1);

    sd_class_t     cand;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand    <= SD_OFF;
            acc_cls <= SD_OFF;
            cnt     <= '0;
        end else if (raw_cls != cand) begin
            cand <= raw_cls;
            cnt  <= '0;
        end else if (cnt == CNT_TOP) begin
            if (acc_cls != cand) acc_cls <= cand;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_ACCEPT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (acc_cls != $past(acc_cls)) |-> ($past(raw_cls) == acc_cls && $past(raw_cls, 2) == acc_cls)); // R2

endmodule

// File: rtl/fl_fault_gen.sv
module fl_fault_gen #(
    parameter int FAULT_ONES = 84
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_req,
    input  logic frame_req,
    output logic fef_sel,
    output logic fef_bit,
    output logic frame_ok
);
    localparam int IW = $clog2(FAULT_ONES + 1);
    localparam logic [IW-1:0] LAST = IW'(FAULT_ONES);

    logic          busy;
    logic [IW-1:0] idx;
    logic          may_start;

    assign may_start = fault_req && !frame_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST) begin
                idx <= '0;
                if (!may_start) busy <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end else if (may_start) begin
            busy <= 1'b1;
            idx  <= '0;
        end
    end

    assign fef_sel  = busy;
    assign fef_bit  = busy && (idx != LAST);
    assign frame_ok = !busy;

    AST_START_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(fef_sel) |-> $past(fault_req && !frame_req)); // R8

    AST_SINGLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fef_sel && !fef_bit) |=> !(fef_sel && !fef_bit)); // R7

    AST_GROUP_RUNS: assert property (@(posedge clk) disable iff (rst)
        (fef_sel && fef_bit) |=> fef_sel); // R9

endmodule

// File: rtl/fiber_link_mon.sv
module fiber_link_mon
    import fl_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 4,
    parameter int FAULT_ONES      = 84
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sd_level,
    input  logic       tx_frame_req,
    output logic       tx_frame_ok,
    output logic       fiber_mode,
    output logic       link_up,
    output logic       link_led,
    output logic       autoneg_bypass,
    output logic       fef_sel,
    output logic       fef_bit
);
    sd_class_t  raw_cls;
    sd_class_t  acc_cls;
    link_view_t view;

    assign raw_cls = classify(sd_level);

    fl_sd_filter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) filt_i (
        .clk     (clk),
        .rst     (rst),
        .raw_cls (raw_cls),
        .acc_cls (acc_cls)
    );

    assign view           = decode_class(acc_cls);
    assign fiber_mode     = view.fiber;
    assign link_up        = view.link;
    assign link_led       = view.led;
    assign autoneg_bypass = view.bypass;

    fl_fault_gen #(.FAULT_ONES(FAULT_ONES)) fgen_i (
        .clk       (clk),
        .rst       (rst),
        .fault_req (view.fault),
        .frame_req (tx_frame_req),
        .fef_sel   (fef_sel),
        .fef_bit   (fef_bit),
        .frame_ok  (tx_frame_ok)
    );

    AST_LINK_NEEDS_FIBER: assert property (@(posedge clk) disable iff (rst)
        link_up |-> fiber_mode); // R5

endmodule

// File: tb/fiber_link_mon_tb_top.sv
module fiber_link_mon_tb_top;
    localparam int DB    = 4;
    localparam int ONES  = 84;
    localparam int GROUP = ONES + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sd_level = 2'b00;
    logic       tx_frame_req = 1'b0;
    logic       tx_frame_ok, fiber_mode, link_up, link_led, autoneg_bypass, fef_sel, fef_bit;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fiber_link_mon #(.DEBOUNCE_CYCLES(DB), .FAULT_ONES(ONES)) dut_i (
        .clk(clk), .rst(rst), .sd_level(sd_level), .tx_frame_req(tx_frame_req),
        .tx_frame_ok(tx_frame_ok), .fiber_mode(fiber_mode), .link_up(link_up),
        .link_led(link_led), .autoneg_bypass(autoneg_bypass),
        .fef_sel(fef_sel), .fef_bit(fef_bit)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_view(input string req, input int f, input int l);
        check(req, "fiber_mode", fiber_mode, f);
        check(req, "link_up", link_up, l);
        check(req, "link_led", link_led, l);
        check("R6", "autoneg_bypass", autoneg_bypass, f);
    endtask

    // Wait until a sample shows bit 0 of a new group; returns 1 if found.
    task automatic wait_group_start(output bit found);
        logic ps = 1'b1, pz = 1'b0;
        found = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (fef_sel && (!ps || pz)) begin
                found = 1;
                break;
            end
            ps = fef_sel;
            pz = fef_sel && !fef_bit;
        end
    endtask

    // Checks one group starting at the current sample. kind 1: raise frame
    // request at bit at_bit; kind 2: switch level to high at bit at_bit.
    task automatic grab_group(input string req, input int at_bit, input int kind);
        int bad = 0;
        for (int i = 0; i < GROUP; i++) begin
            if (i > 0) @(negedge clk);
            if (!fef_sel || fef_bit != (i < ONES) || tx_frame_ok) bad++;
            if (i == at_bit && kind == 1) tx_frame_req = 1'b1;
            if (i == at_bit && kind == 2) sd_level = 2'b10;
        end
        check(req, "group bits not 84 ones then one zero with frame held", bad, 0);
    endtask

    task automatic t_reset;
        cycles(3);
        check_view("R1", 0, 0);
        check("R1", "fef_sel in reset", fef_sel, 0);
        check("R1", "tx_frame_ok in reset", tx_frame_ok, 1);
        rst = 1'b0;
        @(negedge clk);
        check_view("R1", 0, 0);
        check("R1", "fef_sel after reset", fef_sel, 0);
        check("R1", "tx_frame_ok after reset", tx_frame_ok, 1);
    endtask

    task automatic t_debounce;
        sd_level = 2'b10;
        cycles(DB);
        check("R2", "link before window filled", link_up, 0);
        sd_level = 2'b00;
        cycles(12);
        check_view("R2", 0, 0);
        sd_level = 2'b10;
        cycles(DB + 1);
        check("R2", "link after DB+1 samples", link_up, 1);
        sd_level = 2'b00;
        cycles(DB + 3);
        check_view("R3", 0, 0);
        cycles(100);
        check("R3", "no fault below disable", fef_sel, 0);
    endtask

    task automatic t_levels;
        int seen = 0;
        sd_level = 2'b10;
        cycles(DB + 3);
        check_view("R5", 1, 1);
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (fef_sel) seen++;
        end
        check("R5", "fault cycles while high", seen, 0);
        sd_level = 2'b11;
        cycles(DB + 3);
        check_view("R4", 1, 0);
    endtask

    task automatic t_pattern;
        bit found;
        wait_group_start(found);
        check("R4", "fault group starts while low", found, 1);
        grab_group("R7", -1, 0);
        @(negedge clk);
        check("R7", "back-to-back group bit0 sel", fef_sel, 1);
        check("R7", "back-to-back group bit0 value", fef_bit, 1);
        sd_level = 2'b01;
        wait_group_start(found);
        check("R7", "next group found", found, 1);
        grab_group("R7", -1, 0);
    endtask

    task automatic t_frame_hold;
        bit found;
        int leak = 0;
        wait_group_start(found);
        check("R9", "group found", found, 1);
        grab_group("R9", 10, 1);
        @(negedge clk);
        check("R9", "tx_frame_ok after zero bit", tx_frame_ok, 1);
        check("R8", "fef_sel after zero bit with request", fef_sel, 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (fef_sel || !tx_frame_ok) leak++;
        end
        check("R8", "fault cycles during frame", leak, 0);
        tx_frame_req = 1'b0;
        @(negedge clk);
        check("R8", "group starts after frame ends", fef_sel, 1);
        check("R8", "frame_ok drops as group starts", tx_frame_ok, 0);
    endtask

    task automatic t_fault_clear;
        bit found;
        int seen = 0;
        wait_group_start(found);
        check("R9", "group found before clear", found, 1);
        grab_group("R9", 20, 2);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (fef_sel) seen++;
        end
        check("R9", "no group after fault cleared", seen, 0);
        check_view("R5", 1, 1);
        sd_level = 2'b00;
        cycles(DB + 3);
        check_view("R3", 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_debounce();
        t_levels();
        t_pattern();
        t_frame_hold();
        t_fault_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule